// File: doc/BRIEF.md
# Scratchpad Memory Command Controller

This block runs the memory-command layer of a small serial-bus memory device. A bit-level layer below it delivers whole received bytes, a bus-reset strobe and a flag telling whether an incomplete byte was being received. The bit-level layer also fetches bytes to send: it samples `tx_byte` and pulses `tx_ack` once that byte has gone out. Host writes never go straight to storage. They land first in a 32-byte scratchpad, where the host can read them back together with the target address and a status byte. Only after the host echoes the address and status bytes exactly does the block commit the staged bytes to a paged main array (default 16 pages of 32 bytes).

The copy into the main array takes a fixed time, counted by a cycle counter (`COPY_CYCLES`, default 1500 cycles, which is 30 µs at 50 MHz). While that counter runs the block ignores bus resets. A separate read-memory command streams the main array from any address.

Top module: `scp_cmd_ctrl`

## Requirements
- R1: The first byte received after a bus reset selects the command: 0Fh write scratchpad, AAh read scratchpad, 55h copy scratchpad, F0h read memory. Any other value leaves the block ignoring all received bytes and sending FFh until the next bus reset.
- R2: Write scratchpad takes the target address low byte, then the high byte. When the high byte arrives, the scratchpad offset and the ending offset are both set to address bits 4:0 and the three flags are cleared. Each later data byte is stored at the offset, the ending offset takes that offset, and the offset then increments.
- R3: The status byte holds the authorization flag in bit 7, the overflow flag in bit 6, the partial flag in bit 5 and the ending offset in bits 4:0.
- R4: A data byte that arrives after offset 31 has been written sets the overflow flag and is discarded. Neither the scratchpad nor the ending offset changes.
- R5: A bus reset during the write-data phase while `frag_pending` is high sets the partial flag, unless the overflow flag is set. The ending offset is left unchanged.
- R6: Read scratchpad sends the address low byte, the address high byte, the status byte, then scratchpad bytes from offset address[4:0] through 31, then FFh. Each `tx_ack` advances by one byte.
- R7: Copy scratchpad compares three received bytes with the address low byte, the address high byte and the status byte, in that order. On a full match it sets the authorization flag and writes scratchpad offsets address[4:0] through the ending offset to the main array, starting at the target address. On any mismatch it sends FFh until a bus reset and changes nothing.
- R8: After a matching third authorization byte, `copy_busy` is high for exactly `COPY_CYCLES` cycles. A bus reset in that window is ignored. `tx_byte` is 00h from the start of the copy until a bus reset arrives after the copy ends.
- R9: Only write scratchpad clears the authorization flag. Read memory and read scratchpad leave the status byte unchanged.
- R10: Read memory takes a two-byte address, loads it into the target-address register, and streams array bytes from that address, one per `tx_ack`. Addresses at or beyond the array size read as FFh.
- R11: After `rst_n` the address, status, scratchpad and array are all zero, `tx_byte` is FFh and `copy_busy` is low. A bus reset outside a running copy abandons the current command and waits for a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle bus-reset strobe from the bit layer |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| frag_pending | input | 1 | Bit layer holds an incomplete byte (read with bus_reset) |
| tx_ack | input | 1 | Bit layer has sent the current tx_byte |
| tx_byte | output | 8 | Byte to send next |
| copy_busy | output | 1 | Timed copy in progress |

## Verification
The assertions assume that `rx_valid`, `tx_ack` and `bus_reset` are single-cycle strobes from the bit layer. They also assume that `tx_ack` comes only while the block is sending, and that an address is never followed by so many bytes that the streaming address wraps. The stimulus drives each strobe for exactly one clock, at the falling edge, and never raises two strobes in the same cycle. It keeps every target address inside the array, except for one read-memory request placed two bytes below the end, which checks the all-ones reads past the array. The only reset the stimulus issues while `copy_busy` is high is the one meant to be ignored.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int PAGE_BYTES = 32;
    localparam int OFF_W      = 5;

    localparam logic [7:0] OP_WR_PAD = 8'h0F;
    localparam logic [7:0] OP_RD_PAD = 8'hAA;
    localparam logic [7:0] OP_COPY   = 8'h55;
    localparam logic [7:0] OP_RD_MEM = 8'hF0;

    typedef enum logic [3:0] {
        S_CMD,
        S_WTA1,
        S_WTA2,
        S_WDATA,
        S_RTX,
        S_CA1,
        S_CA2,
        S_CA3,
        S_COPY,
        S_ZEROS,
        S_ONES,
        S_MTA1,
        S_MTA2,
        S_MSTR,
        S_HOLD
    } scp_state_e;

    typedef struct packed {
        scp_state_e       st;
        logic [15:0]      ta;
        logic             aa;
        logic             of;
        logic             pf;
        logic [OFF_W-1:0] eo;
        logic [OFF_W:0]   off;
        logic [1:0]       hdr;
        logic             auth_ok;
        logic [15:0]      mad;
    } scp_regs_t;

endpackage

// File: rtl/scp_byte_ram.sv
module scp_byte_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/scp_copy_timer.sv
module scp_copy_timer #(
    parameter int CYCLES = 1500,
    parameter int CW     = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [CW-1:0] elapsed
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
        end else if (t_q.busy) begin
            if (t_q.cnt == LAST) t_d.busy = 1'b0;
            else                 t_d.cnt  = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy    = t_q.busy;
    assign elapsed = t_q.cnt;

    // R8: the window never runs past its length
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elapsed <= LAST));

    // R8: busy ends only after the full count
    assert_window_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(elapsed) == LAST));

endmodule

// File: rtl/scp_cmd_ctrl.sv
module scp_cmd_ctrl
    import scp_pkg::*;
#(
    parameter int PAGES       = 16,
    parameter int COPY_CYCLES = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       frag_pending,
    input  logic       tx_ack,
    output logic [7:0] tx_byte,
    output logic       copy_busy
);

    localparam int ARR_BYTES = PAGES * PAGE_BYTES;
    localparam int ARR_AW    = $clog2(ARR_BYTES);
    localparam int CW        = $clog2(COPY_CYCLES + 1);
    localparam logic [15:0] ARR_END = 16'(ARR_BYTES);

    scp_regs_t r_d, r_q;

    logic              tmr_start, tmr_busy;
    logic [CW-1:0]     tmr_elapsed;
    logic              pad_we;
    logic [OFF_W-1:0]  pad_waddr, pad_raddr;
    logic [7:0]        pad_wdata, pad_rdata;
    logic              arr_we;
    logic [ARR_AW-1:0] arr_waddr, arr_raddr;
    logic [7:0]        arr_rdata;
    logic [7:0]        status;
    logic [OFF_W-1:0]  span, cp_off;
    logic              cp_active, ta_in_range;

    assign status = {r_q.aa, r_q.of, r_q.pf, r_q.eo};

    scp_copy_timer #(.CYCLES(COPY_CYCLES), .CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .busy    (tmr_busy),
        .elapsed (tmr_elapsed)
    );

    scp_byte_ram #(.DEPTH(PAGE_BYTES), .AW(OFF_W)) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pad_we),
        .waddr (pad_waddr),
        .wdata (pad_wdata),
        .raddr (pad_raddr),
        .rdata (pad_rdata)
    );

    scp_byte_ram #(.DEPTH(ARR_BYTES), .AW(ARR_AW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (pad_rdata),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    // copy sequencing from the timer's elapsed count
    always_comb begin
        span        = r_q.eo - r_q.ta[OFF_W-1:0];
        cp_off      = r_q.ta[OFF_W-1:0] + tmr_elapsed[OFF_W-1:0];
        cp_active   = (r_q.st == S_COPY) && tmr_busy &&
                      (tmr_elapsed <= CW'(span));
        ta_in_range = (r_q.ta < ARR_END);
        arr_we      = cp_active && ta_in_range;
        arr_waddr   = {r_q.ta[ARR_AW-1:OFF_W], cp_off};
        arr_raddr   = r_q.mad[ARR_AW-1:0];
        pad_raddr   = (r_q.st == S_COPY) ? cp_off : r_q.off[OFF_W-1:0];
    end

    // next-state logic
    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        pad_we    = 1'b0;
        pad_waddr = r_q.off[OFF_W-1:0];
        pad_wdata = rx_byte;

        if (bus_reset && !(r_q.st == S_COPY && tmr_busy)) begin
            if (r_q.st == S_WDATA && frag_pending && !r_q.of) r_d.pf = 1'b1;
            r_d.st = S_CMD;
        end else begin
            unique case (r_q.st)
                S_CMD: if (rx_valid) begin
                    unique case (rx_byte)
                        OP_WR_PAD: r_d.st = S_WTA1;
                        OP_RD_PAD: begin
                            r_d.st  = S_RTX;
                            r_d.hdr = 2'd0;
                            r_d.off = {1'b0, r_q.ta[OFF_W-1:0]};
                        end
                        OP_COPY: begin
                            r_d.st      = S_CA1;
                            r_d.auth_ok = 1'b1;
                        end
                        OP_RD_MEM: r_d.st = S_MTA1;
                        default:   r_d.st = S_HOLD;
                    endcase
                end
                S_WTA1: if (rx_valid) begin
                    r_d.ta[7:0] = rx_byte;
                    r_d.st      = S_WTA2;
                end
                S_WTA2: if (rx_valid) begin
                    r_d.ta[15:8] = rx_byte;
                    r_d.off      = {1'b0, r_q.ta[OFF_W-1:0]};
                    r_d.eo       = r_q.ta[OFF_W-1:0];
                    r_d.aa       = 1'b0;
                    r_d.of       = 1'b0;
                    r_d.pf       = 1'b0;
                    r_d.st       = S_WDATA;
                end
                S_WDATA: if (rx_valid) begin
                    if (r_q.off[OFF_W]) begin
                        r_d.of = 1'b1;
                    end else begin
                        pad_we  = 1'b1;
                        r_d.eo  = r_q.off[OFF_W-1:0];
                        r_d.off = r_q.off + 1'b1;
                    end
                end
                S_RTX: if (tx_ack) begin
                    if (r_q.hdr != 2'd3)     r_d.hdr = r_q.hdr + 1'b1;
                    else if (!r_q.off[OFF_W]) r_d.off = r_q.off + 1'b1;
                end
                S_CA1: if (rx_valid) begin
                    r_d.auth_ok = r_q.auth_ok && (rx_byte == r_q.ta[7:0]);
                    r_d.st      = S_CA2;
                end
                S_CA2: if (rx_valid) begin
                    r_d.auth_ok = r_q.auth_ok && (rx_byte == r_q.ta[15:8]);
                    r_d.st      = S_CA3;
                end
                S_CA3: if (rx_valid) begin
                    if (r_q.auth_ok && rx_byte == status) begin
                        r_d.aa    = 1'b1;
                        tmr_start = 1'b1;
                        r_d.st    = S_COPY;
                    end else begin
                        r_d.st = S_ONES;
                    end
                end
                S_COPY: if (!tmr_busy) r_d.st = S_ZEROS;
                S_MTA1: if (rx_valid) begin
                    r_d.ta[7:0] = rx_byte;
                    r_d.st      = S_MTA2;
                end
                S_MTA2: if (rx_valid) begin
                    r_d.ta[15:8] = rx_byte;
                    r_d.mad      = {rx_byte, r_q.ta[7:0]};
                    r_d.st       = S_MSTR;
                end
                S_MSTR: if (tx_ack && r_q.mad < ARR_END) r_d.mad = r_q.mad + 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // transmit byte selection
    always_comb begin
        tx_byte = 8'hFF;
        unique case (r_q.st)
            S_RTX: begin
                unique case (r_q.hdr)
                    2'd0:    tx_byte = r_q.ta[7:0];
                    2'd1:    tx_byte = r_q.ta[15:8];
                    2'd2:    tx_byte = status;
                    default: tx_byte = r_q.off[OFF_W] ? 8'hFF : pad_rdata;
                endcase
            end
            S_COPY, S_ZEROS: tx_byte = 8'h00;
            S_MSTR: tx_byte = (r_q.mad < ARR_END) ? arr_rdata : 8'hFF;
            default: tx_byte = 8'hFF;
        endcase
    end

    assign copy_busy = tmr_busy;

    // R9: the authorization flag falls only on a write address byte
    assert_aa_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.aa) |-> $past(r_q.st == S_WTA2 && rx_valid));

    // R8: a running copy is not left by a bus reset
    assert_copy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_COPY && tmr_busy) |=> (r_q.st == S_COPY || r_q.st == S_ZEROS));

    // R7: the main array is written only by an authorized copy
    assert_arr_write_auth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (r_q.st == S_COPY && r_q.aa));

    // R10: status is frozen while streaming memory
    assert_status_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_MSTR) |=> $stable(status));

    // R4: once past the last offset the ending offset stays put
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WDATA && r_q.off[OFF_W]) |=> $stable(r_q.eo));

endmodule

// File: tb/scp_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module scp_cmd_ctrl_bench;

    localparam int PAGES = 16;
    localparam int NB    = PAGES * 32;
    localparam int CC    = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       frag_pending = 1'b0;
    logic       tx_ack = 1'b0;
    logic [7:0] tx_byte;
    logic       copy_busy;

    always #10 clk = ~clk;

    scp_cmd_ctrl #(.PAGES(PAGES), .COPY_CYCLES(CC)) u_scp_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .frag_pending(frag_pending), .tx_ack(tx_ack),
        .tx_byte(tx_byte), .copy_busy(copy_busy)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  mem_m [NB];
    logic [7:0]  pad_m [32];
    logic [15:0] ta_m = '0;
    logic        aa_m = 0, of_m = 0, pf_m = 0;
    logic [4:0]  eo_m = '0;

    function automatic logic [7:0] es_m();
        return {aa_m, of_m, pf_m, eo_m};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic breset(input logic frag);
        frag_pending = frag; bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0; frag_pending = 1'b0;
    endtask

    task automatic take(output logic [7:0] b);
        b = tx_byte; tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    // R2 R4 R5: write scratchpad and update the model
    task automatic do_write(input logic [15:0] ta, input int n, input int seed, input logic frag);
        int off;
        breset(1'b0);
        send(8'h0F); send(ta[7:0]); send(ta[15:8]);
        ta_m = ta; aa_m = 0; of_m = 0; pf_m = 0; eo_m = ta[4:0];
        off = int'(ta[4:0]);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((seed * 29 + i * 13 + 7) & 255);
            send(d);
            if (off > 31) of_m = 1;
            else begin pad_m[off] = d; eo_m = 5'(off); off++; end
        end
        if (frag && !of_m) pf_m = 1;
        breset(frag);
    endtask

    // R6 R3 R9: read scratchpad and compare
    task automatic do_rdpad(input string tag);
        logic [7:0] b;
        breset(1'b0);
        send(8'hAA);
        take(b); chk({tag, " R6 TA1"}, b, ta_m[7:0]);
        take(b); chk({tag, " R6 TA2"}, b, ta_m[15:8]);
        take(b); chk({tag, " R3 R9 status"}, b, es_m());
        for (int o = int'(ta_m[4:0]); o < 34; o++) begin
            take(b);
            chk({tag, " R6 data"}, b, (o < 32) ? pad_m[o] : 8'hFF);
        end
    endtask

    // R7 R8: copy, either matching or with one corrupted echo byte
    task automatic do_copy(input int bad, input bit rst_mid);
        logic [7:0] e0, e1, e2;
        int cnt;
        e0 = ta_m[7:0]; e1 = ta_m[15:8]; e2 = es_m();
        if (bad == 0) e0 ^= 8'h01;
        if (bad == 1) e1 ^= 8'h80;
        if (bad == 2) e2 ^= 8'h10;
        breset(1'b0);
        send(8'h55); send(e0); send(e1); send(e2);
        if (bad >= 0) begin
            chk("R7 mismatch busy", copy_busy, 0);
            chk("R7 mismatch ones", tx_byte, 8'hFF);
            @(negedge clk);
            chk("R7 mismatch ones held", tx_byte, 8'hFF);
        end else begin
            cnt = 0;
            chk("R8 zeros during copy", tx_byte, 8'h00);
            while (copy_busy && cnt < CC + 10) begin
                cnt++;
                bus_reset = (rst_mid && cnt == 5);
                @(negedge clk);
            end
            bus_reset = 1'b0;
            chk("R8 busy length", cnt, CC);
            chk("R8 zeros after copy", tx_byte, 8'h00);
            @(negedge clk);
            chk("R8 zeros held", tx_byte, 8'h00);
            aa_m = 1;
            for (int o = int'(ta_m[4:0]); o <= int'(eo_m); o++)
                mem_m[{ta_m[8:5], 5'(o)}] = pad_m[o];
        end
        breset(1'b0);
    endtask

    // R10: read memory from an address
    task automatic do_rdmem(input logic [15:0] a, input int n, input string tag);
        logic [7:0] b;
        breset(1'b0);
        send(8'hF0); send(a[7:0]); send(a[15:8]);
        ta_m = a;
        for (int i = 0; i < n; i++) begin
            take(b);
            chk({tag, " R10 data"}, b, (int'(a) + i < NB) ? mem_m[int'(a) + i] : 8'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        for (int i = 0; i < NB; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < 32; i++) pad_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset tx", tx_byte, 8'hFF);
        chk("R11 reset busy", copy_busy, 0);
        do_rdpad("R11 reset pad");

        // sweep every page with varied start offsets and lengths
        for (int p = 0; p < PAGES; p++) begin
            int t, n;
            t = (p * 7) % 32;
            n = 1 + (p * 3) % (32 - t);
            do_write(16'(p * 32 + t), n, p, 1'b0);
            do_rdpad("R2 sweep");
            if (p >= 5 && p <= 7) begin
                do_copy(p - 5, 1'b0);
                do_rdmem(16'(p * 32), 32, "R7 after mismatch");
            end
            do_copy(-1, p == 3);
            do_rdmem(16'(p * 32), 32, "R7 after copy");
            do_rdpad("R9 status kept");
        end

        // R5 partial byte, then a copy honouring it
        do_write(16'h0045, 2, 40, 1'b1);
        do_rdpad("R5 partial");
        do_copy(-1, 1'b0);
        do_rdmem(16'h0040, 32, "R5 copy");

        // R4 overflow, partial flag suppressed
        do_write(16'h01DE, 4, 41, 1'b1);
        do_rdpad("R4 overflow");

        // R2 no data bytes: ending offset equals start
        do_write(16'h0093, 0, 42, 1'b0);
        do_rdpad("R2 empty write");

        // R1 unknown command ignores following bytes
        breset(1'b0);
        send(8'h33);
        chk("R1 unknown ones", tx_byte, 8'hFF);
        send(8'h0F); send(8'h00); send(8'h00); send(8'hAB);
        chk("R1 unknown ones held", tx_byte, 8'hFF);
        do_rdpad("R1 after unknown");

        // R11 abort of read memory, then a normal command
        breset(1'b0);
        send(8'hF0); send(8'h20); send(8'h00);
        take(b); take(b);
        breset(1'b0);
        chk("R11 abort idle", tx_byte, 8'hFF);
        ta_m = 16'h0020;
        do_rdpad("R11 after abort");

        // R10 past the end and full array
        do_rdmem(16'(NB - 2), 4, "R10 end");
        do_rdmem(16'h0000, NB + 2, "R10 full");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule